// File: doc/BRIEF.md
# Bus Tenure Watchdog

This unit sits beside a shared-bus arbiter and watches for three kinds of stall: an address phase that never hands over to a data phase, a data phase that never receives its acknowledge, and a bus that stays quiet for too long. Each watch has its own counter, enable bit, timeout field, sticky status bit and interrupt enable. When a data phase overruns its budget, the unit drives a one-cycle transfer error back onto the bus so the waiting master is released. The other two watches only raise status.

Software sets each timeout as a 28-bit value in units of 16 clock cycles. This value is held in bits 31:4 of a 32-bit register word. The unit is configured and serviced through a small word-indexed register port. Writes take effect on the clock edge, and reads are combinational. The word indices are: 0 enables, 1 status, 2 interrupt enables, 3 address timeout, 4 data timeout, 5 idle timeout. Any other index reads as zero. In the enable, status and interrupt-enable words, bit 0 belongs to the address watch, bit 1 to the data watch and bit 2 to the idle watch.

Top module: `bus_tenure_wdog`

## Requirements
- R1: After reset, these words read zero: enables, status and interrupt enables. The three timeout words read 0xFFFFFFF0. `xfer_err` and `irq` are low.
- R2: A write to a timeout word stores only bits 31:4. Bits 3:0 always read back as zero.
- R3: A data phase starts on the edge that first samples `bus_busy` high. With data timeout value T, `xfer_err` is high in the cycle after the (16*T+16)-th rising edge that follows that start edge.
- R4: If `xfer_ack` is sampled high on or before that (16*T+16)-th edge, the data phase ends. No `xfer_err` is issued and data status (bit 1) stays clear.
- R5: A data expiry does three things. It raises `xfer_err` for exactly one cycle. It sets status bit 1. It stops the data counter, so no further error occurs while `bus_busy` stays high.
- R6: An address phase starts on the edge that samples `addr_start` high and ends on the edge that first samples `bus_busy` high. If it is still open 16*T+16 edges after its start, status bit 0 is set and no `xfer_err` is driven.
- R7: The idle counter restarts on every edge that samples `addr_start` or `bus_busy` high. Status bit 2 is set 16*T+16 edges after the last such edge. After it fires, it does not fire again until new bus activity occurs.
- R8: The enable word controls the three watches: bit 0 address, bit 1 data, bit 2 idle. Clearing an enable bit stops and zeroes its counter, and the counter does not restart until its next start event. A disabled watch never sets status or drives `xfer_err`.
- R9: Writing a 1 to a status bit (word 1) clears it. Writing a 0 leaves it unchanged. A status bit becomes set only through an expiry of its own watch.
- R10: `irq` is high exactly when some status bit is set together with the same bit of the interrupt-enable word (word 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_busy | input | 1 | Data bus held by a master |
| addr_start | input | 1 | Start of an address phase |
| xfer_ack | input | 1 | Transfer acknowledge for the data phase |
| xfer_err | output | 1 | Transfer error pulse on data timeout |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures each expiry latency to the exact edge for two timeout values. This catches a counter that is one step short or one step long, and a timeout field shifted by a bit.

It raises the acknowledge on the very last permitted edge. A design that lets expiry win over the acknowledge would emit a spurious error there.

It holds the bus busy after a data error and stays silent after an idle expiry. A counter that fails to clear would then repeat the error or the interrupt.

It toggles an enable in the middle of a phase. A design that merely pauses the counter, instead of clearing it, would still expire on that old phase.

// File: rtl/btw_pkg.sv
package btw_pkg;
  localparam int NUM_TMR = 3;

  typedef enum int {
    TMR_ADDR = 0,
    TMR_DATA = 1,
    TMR_IDLE = 2
  } tmr_e;

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_IEN  = 3'd2;
  localparam logic [2:0] IDX_TO0  = 3'd3;
endpackage

// File: rtl/btw_timer.sv
module btw_timer #(
  parameter int DW     = 32,
  parameter int STEP_W = 4,
  localparam int TO_W  = DW - STEP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            restart,
  input  logic            halt,
  input  logic [TO_W-1:0] limit_hi,
  output logic            fire
);
  logic          run_q, run_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] limit;
  logic          upd;

  assign limit = {limit_hi, {STEP_W{1'b1}}};
  assign fire  = en && run_q && !halt && !restart && (cnt_q >= limit);
  assign upd   = run_q | (en & restart);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!en || halt || fire) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (restart) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // R8: a cleared enable leaves the counter idle and zero
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run_q && cnt_q == '0));

  // R5: an expiry stops the counter
  a_r5_fire_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !run_q);

  // R4: a halt always ends the run
  a_r4_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !run_q);
endmodule

// File: rtl/btw_regs.sv
module btw_regs
  import btw_pkg::*;
#(
  parameter int DW     = 32,
  parameter int STEP_W = 4,
  parameter int AW     = 3,
  localparam int TO_W  = DW - STEP_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  input  logic [NUM_TMR-1:0]            set_i,
  output logic [DW-1:0]                 rdata,
  output logic [NUM_TMR-1:0]            en_o,
  output logic [NUM_TMR-1:0][TO_W-1:0]  to_o,
  output logic                          irq
);
  logic [NUM_TMR-1:0]           ctrl_q, ctrl_d;
  logic [NUM_TMR-1:0]           ien_q, ien_d;
  logic [NUM_TMR-1:0]           stat_q, stat_d;
  logic [NUM_TMR-1:0][TO_W-1:0] to_q, to_d;
  logic                         upd;

  assign upd = wr | (|set_i);

  always_comb begin
    ctrl_d = ctrl_q;
    ien_d  = ien_q;
    stat_d = stat_q;
    to_d   = to_q;
    if (wr) begin
      if (addr == AW'(IDX_CTRL)) ctrl_d = wdata[NUM_TMR-1:0];
      if (addr == AW'(IDX_IEN))  ien_d  = wdata[NUM_TMR-1:0];
      if (addr == AW'(IDX_STAT)) stat_d = stat_q & ~wdata[NUM_TMR-1:0];
      for (int k = 0; k < NUM_TMR; k++) begin
        if (addr == AW'(int'(IDX_TO0) + k)) to_d[k] = wdata[DW-1:STEP_W];
      end
    end
    stat_d = stat_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      stat_q <= '0;
      to_q   <= {NUM_TMR{ {TO_W{1'b1}} }};
    end else if (upd) begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
      stat_q <= stat_d;
      to_q   <= to_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(IDX_CTRL)) rdata[NUM_TMR-1:0] = ctrl_q;
    if (addr == AW'(IDX_STAT)) rdata[NUM_TMR-1:0] = stat_q;
    if (addr == AW'(IDX_IEN))  rdata[NUM_TMR-1:0] = ien_q;
    for (int k = 0; k < NUM_TMR; k++) begin
      if (addr == AW'(int'(IDX_TO0) + k)) rdata = {to_q[k], {STEP_W{1'b0}}};
    end
  end

  assign en_o = ctrl_q;
  assign to_o = to_q;
  assign irq  = |(stat_q & ien_q);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R9: a status bit rises only after an expiry of its own watch
    a_r9_status_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[i]) |-> $past(set_i[i]));
    // R9: writing one clears the bit unless a new expiry arrives
    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AW'(IDX_STAT) && wdata[i] && !set_i[i]) |=> !stat_q[i]);
  end
endmodule

// File: rtl/bus_tenure_wdog.sv
module bus_tenure_wdog
  import btw_pkg::*;
#(
  parameter int DW     = 32,
  parameter int STEP_W = 4,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_busy,
  input  logic          addr_start,
  input  logic          xfer_ack,
  output logic          xfer_err,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int TO_W = DW - STEP_W;

  logic                         busy_q;
  logic                         busy_rise;
  logic                         err_q;
  logic [NUM_TMR-1:0]           en;
  logic [NUM_TMR-1:0][TO_W-1:0] to_val;
  logic [NUM_TMR-1:0]           restart, halt, fire;

  assign busy_rise = bus_busy & ~busy_q;

  always_comb begin
    restart           = '0;
    halt              = '0;
    restart[TMR_ADDR] = addr_start;
    halt[TMR_ADDR]    = busy_rise;
    restart[TMR_DATA] = busy_rise;
    halt[TMR_DATA]    = xfer_ack;
    restart[TMR_IDLE] = addr_start | bus_busy;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    btw_timer #(.DW(DW), .STEP_W(STEP_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en[i]),
      .restart  (restart[i]),
      .halt     (halt[i]),
      .limit_hi (to_val[i]),
      .fire     (fire[i])
    );
  end

  btw_regs #(.DW(DW), .STEP_W(STEP_W), .AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .set_i (fire),
    .rdata (reg_rdata),
    .en_o  (en),
    .to_o  (to_val),
    .irq   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= bus_busy;
      err_q  <= fire[TMR_DATA];
    end
  end

  assign xfer_err = err_q;

  // R5: the error is a single-cycle pulse
  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !xfer_err);

  // R5: the error comes with data status set
  a_r5_err_status: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> u_regs.stat_q[TMR_DATA]);

  // R4: an acknowledge blocks the error on the following cycle
  a_r4_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_err);

  // R10: interrupt follows enabled status
  a_r10_irq_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|u_regs.ien_q));
endmodule

// File: tb/bus_tenure_wdog_bench.sv
`timescale 1ns/1ps
module bus_tenure_wdog_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_busy, addr_start, xfer_ack, reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        xfer_err, irq;

  int checks = 0;
  int errors = 0;
  int err_pulses = 0;
  bit done = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2;
  localparam logic [2:0] A_TOA = 3'd3, A_TOD = 3'd4, A_TOI = 3'd5;

  always #2.5 clk = ~clk;

  bus_tenure_wdog u_bus_tenure_wdog (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .addr_start(addr_start),
    .xfer_ack(xfer_ack), .xfer_err(xfer_err), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  always @(negedge clk) if (xfer_err) err_pulses++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // sel 0: xfer_err, 1..3: status bit sel-1 (reg_addr must point at status)
  task automatic count_until(input int sel, input int maxc, output int n);
    n = 0;
    for (int i = 0; i < maxc; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (sel == 0 ? xfer_err : reg_rdata[sel-1]) return;
    end
    n = -1;
  endtask

  task automatic cleanup();
    @(negedge clk);
    bus_busy = 1'b0; addr_start = 1'b0; xfer_ack = 1'b0;
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_STAT, 32'h7);
    wr_reg(A_IEN, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_CTRL, d); chk(d == 0, "R1 ctrl reset", d, 0);
    rd_reg(A_STAT, d); chk(d == 0, "R1 status reset", d, 0);
    rd_reg(A_IEN, d);  chk(d == 0, "R1 irq enable reset", d, 0);
    rd_reg(A_TOA, d);  chk(d == 32'hFFFFFFF0, "R1 addr timeout reset", d, 32'hFFFFFFF0);
    rd_reg(A_TOD, d);  chk(d == 32'hFFFFFFF0, "R1 data timeout reset", d, 32'hFFFFFFF0);
    rd_reg(A_TOI, d);  chk(d == 32'hFFFFFFF0, "R1 idle timeout reset", d, 32'hFFFFFFF0);
    chk(xfer_err == 0, "R1 xfer_err reset", xfer_err, 0);
    chk(irq == 0, "R1 irq reset", irq, 0);
  endtask

  task automatic t_to_format();
    logic [31:0] d;
    wr_reg(A_TOD, 32'h0000001F);
    rd_reg(A_TOD, d); chk(d == 32'h10, "R2 low bits dropped", d, 32'h10);
    wr_reg(A_TOA, 32'hABCDE12F);
    rd_reg(A_TOA, d); chk(d == 32'hABCDE120, "R2 high bits kept", d, 32'hABCDE120);
  endtask

  task automatic t_data_expiry();
    int n, p;
    wr_reg(A_TOD, 32'h1F);
    wr_reg(A_CTRL, 32'h2);
    @(negedge clk); reg_addr = A_STAT; bus_busy = 1'b1;
    @(posedge clk);
    count_until(0, 200, n);
    chk(n == 32, "R3 data latency T=1", n, 32);
    chk(reg_rdata[1] == 1'b1, "R5 data status set", reg_rdata[1], 1);
    @(posedge clk); @(negedge clk);
    chk(xfer_err == 0, "R5 error single cycle", xfer_err, 0);
    p = err_pulses;
    repeat (60) @(negedge clk);
    chk(err_pulses == p, "R5 no repeat while busy held", err_pulses - p, 0);
    bus_busy = 1'b0;
    wr_reg(A_STAT, 32'h2);
    wr_reg(A_TOD, 32'h20);
    @(negedge clk); reg_addr = A_STAT; bus_busy = 1'b1;
    @(posedge clk);
    count_until(0, 200, n);
    chk(n == 48, "R3 data latency T=2", n, 48);
    cleanup();
  endtask

  task automatic t_ack_stops();
    int p;
    wr_reg(A_TOD, 32'h10);
    wr_reg(A_CTRL, 32'h2);
    @(negedge clk); reg_addr = A_STAT; bus_busy = 1'b1;
    p = err_pulses;
    @(posedge clk);
    repeat (31) @(posedge clk);
    @(negedge clk); xfer_ack = 1'b1;
    @(posedge clk);
    @(negedge clk); xfer_ack = 1'b0;
    chk(xfer_err == 0, "R4 ack on last edge blocks error", xfer_err, 0);
    repeat (40) @(negedge clk);
    chk(err_pulses == p, "R4 no error after ack", err_pulses - p, 0);
    chk(reg_rdata[1] == 0, "R4 data status clear", reg_rdata[1], 0);
    cleanup();
  endtask

  task automatic t_addr();
    int n, p;
    wr_reg(A_TOA, 32'h10);
    wr_reg(A_CTRL, 32'h1);
    p = err_pulses;
    @(negedge clk); reg_addr = A_STAT; addr_start = 1'b1;
    @(posedge clk);
    @(negedge clk); addr_start = 1'b0;
    count_until(1, 200, n);
    chk(n == 32, "R6 addr latency", n, 32);
    chk(err_pulses == p, "R6 no transfer error", err_pulses - p, 0);
    wr_reg(A_STAT, 32'h1);
    @(negedge clk); reg_addr = A_STAT; addr_start = 1'b1;
    @(negedge clk); addr_start = 1'b0;
    repeat (10) @(negedge clk);
    bus_busy = 1'b1;
    repeat (60) @(negedge clk);
    chk(reg_rdata[0] == 0, "R6 busy ends address phase", reg_rdata[0], 0);
    cleanup();
  endtask

  task automatic t_idle();
    int n;
    wr_reg(A_TOI, 32'h10);
    wr_reg(A_CTRL, 32'h4);
    @(negedge clk); reg_addr = A_STAT; bus_busy = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_busy = 1'b0;
    count_until(3, 200, n);
    chk(n == 32, "R7 idle latency", n, 32);
    wr_reg(A_STAT, 32'h4);
    @(negedge clk); reg_addr = A_STAT;
    repeat (100) @(negedge clk);
    chk(reg_rdata[2] == 0, "R7 no refire without activity", reg_rdata[2], 0);
    @(negedge clk); addr_start = 1'b1;
    @(posedge clk);
    @(negedge clk); addr_start = 1'b0;
    count_until(3, 200, n);
    chk(n == 32, "R7 rearmed by address start", n, 32);
    cleanup();
  endtask

  task automatic t_enable();
    int n, p;
    wr_reg(A_TOD, 32'h10);
    p = err_pulses;
    @(negedge clk); reg_addr = A_STAT; bus_busy = 1'b1;
    repeat (60) @(negedge clk);
    chk(err_pulses == p, "R8 disabled data watch silent", err_pulses - p, 0);
    chk(reg_rdata == 0, "R8 disabled sets no status", reg_rdata, 0);
    bus_busy = 1'b0;
    wr_reg(A_CTRL, 32'h2);
    @(negedge clk); bus_busy = 1'b1;
    repeat (20) @(negedge clk);
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_CTRL, 32'h2);
    @(negedge clk); reg_addr = A_STAT;
    repeat (60) @(negedge clk);
    chk(err_pulses == p, "R8 disable clears running count", err_pulses - p, 0);
    chk(reg_rdata[1] == 0, "R8 no status after re-enable", reg_rdata[1], 0);
    bus_busy = 1'b0;
    @(negedge clk); bus_busy = 1'b1;
    @(posedge clk);
    count_until(0, 200, n);
    chk(n == 32, "R8 counts from zero on next start", n, 32);
    cleanup();
  endtask

  task automatic t_w1c_irq();
    int n;
    logic [31:0] d;
    wr_reg(A_TOD, 32'h10);
    wr_reg(A_TOA, 32'h10);
    wr_reg(A_CTRL, 32'h2);
    @(negedge clk); reg_addr = A_STAT; bus_busy = 1'b1;
    @(posedge clk);
    count_until(0, 200, n);
    bus_busy = 1'b0;
    wr_reg(A_CTRL, 32'h1);
    @(negedge clk); reg_addr = A_STAT; addr_start = 1'b1;
    @(posedge clk);
    @(negedge clk); addr_start = 1'b0;
    count_until(1, 200, n);
    wr_reg(A_CTRL, 32'h0);
    rd_reg(A_STAT, d); chk(d == 32'h3, "R9 both status bits set", d, 3);
    chk(irq == 0, "R10 irq masked", irq, 0);
    wr_reg(A_IEN, 32'h2);
    @(negedge clk); chk(irq == 1, "R10 irq on data status", irq, 1);
    wr_reg(A_STAT, 32'h1);
    rd_reg(A_STAT, d); chk(d == 32'h2, "R9 clear only written one", d, 2);
    wr_reg(A_IEN, 32'h1);
    @(negedge clk); chk(irq == 0, "R10 irq off when enable mismatched", irq, 0);
    wr_reg(A_STAT, 32'h2);
    rd_reg(A_STAT, d); chk(d == 32'h0, "R9 status cleared", d, 0);
    cleanup();
  endtask

  initial begin
    rst_n = 1'b0;
    bus_busy = 1'b0; addr_start = 1'b0; xfer_ack = 1'b0;
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_to_format();
    t_data_expiry();
    t_ack_stops();
    t_addr();
    t_idle();
    t_enable();
    t_w1c_irq();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule